// File: doc/BRIEF.md
# Multi-Mode Configurable Logic Cell

This block is a single programmable logic element of the kind tiled across a fine-grained logic array. A three-bit mode word picks its function. It can act as a four-input lookup table, a one-bit full adder, a one-bit slice of an array multiplier (an AND gate feeding a full adder), a one-bit counter stage, or a two-way multiplexer. The multiplexer mode exists for data-switching paths through the array.

All modes share one output stage. The function value is captured in a flip-flop on each rising clock edge. The main result is either that flip-flop or the raw combinational value, chosen by a bypass select. The same result can drive a tri-state pin gated by an output enable. The flip-flop value is always presented on a feedback output for use in the next cycle.

Carry-out never passes through the flip-flop. Neighbouring cells can therefore be chained into ripple adders, ripple counters and multiplier rows that settle within one cycle.

Top module: `cfg_logic_cell`

## Requirements
- R1: With mode 000 (lookup) and bypass high, result equals bit `cfgLut[dIn]`, where dIn[0] is the least significant address bit, and carry-out is 0.
- R2: With mode 001 (adder) and bypass high, {carryOut, result} equals dIn[0] + dIn[1] + carryIn.
- R3: With mode 010 (multiplier slice) and bypass high, {carryOut, result} equals (dIn[0] AND dIn[1]) + dIn[2] + carryIn.
- R4: With mode 011 (counter stage), the stored bit inverts at a clock edge where carryIn is 1 and keeps its value where carryIn is 0. Carry-out is the stored bit AND carryIn, and with bypass high the result is the stored bit XOR carryIn.
- R5: With mode 100 (multiplexer) and bypass high, result is dIn[1] when dIn[2] is 1 and dIn[0] otherwise, and carry-out is 0.
- R6: triOut equals result while outEn is 1 and is high-impedance while outEn is 0, in every mode.
- R7: With bypass low in a defined mode, result equals the function value captured at the previous rising clock edge.
- R8: A clock edge with rst high clears the stored bit to 0.
- R9: fbOut always shows the stored bit, whatever the bypass select.
- R10: Carry-out is combinational: it follows the current inputs in the same cycle, with no register in its path.
- R11: Mode codes 101, 110 and 111 hold the stored bit and force result and carry-out to 0.
- R12: Four cells chained through carry-out to carry-in form a 4-bit ripple adder that settles in one cycle (adder mode, bypass high). Four counter-mode cells chained the same way, with the first carry-in as enable, count up modulo 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset of the stored bit, active high |
| dIn | input | LUT_INPUTS | Data inputs; also the lookup address |
| carryIn | input | 1 | Carry / count-enable input from the previous cell |
| outEn | input | 1 | Enable for the tri-state output |
| bypassSel | input | 1 | 1 selects the combinational value for result, 0 the stored bit |
| cfgMode | input | 3 | Function select: 000 lookup, 001 adder, 010 multiplier, 011 counter, 100 mux |
| cfgLut | input | 2**LUT_INPUTS | Lookup table contents |
| result | output | 1 | Main cell output |
| carryOut | output | 1 | Combinational carry to the next cell |
| triOut | output | 1 | Tri-state copy of result |
| fbOut | output | 1 | Stored bit, fed back for the next cycle |

## Verification
The stored bit is the only state in the cell. A wrong value there shows on fbOut right after the clock edge that wrote it. When bypass is low it also shows on result, and in counter mode it reaches carryOut in the same cycle. A corrupt counter bit therefore reaches every downstream cell of a chain before the next edge. A decode fault in the mode logic shows up combinationally on result or carryOut in the same cycle the mode is applied. A missing hold in the undefined codes shows on fbOut one edge later.

// File: rtl/lcell_pkg.sv
package lcell_pkg;

  localparam int MODE_W = 3;

  localparam logic [MODE_W-1:0] MODE_LUT = 3'b000;
  localparam logic [MODE_W-1:0] MODE_ADD = 3'b001;
  localparam logic [MODE_W-1:0] MODE_MUL = 3'b010;
  localparam logic [MODE_W-1:0] MODE_CNT = 3'b011;
  localparam logic [MODE_W-1:0] MODE_MUX = 3'b100;

  // Strobes from the decode to the datapath
  typedef struct packed {
    logic selLut;
    logic selAdd;
    logic selMul;
    logic selCnt;
    logic selMux;
    logic regLoad;
    logic forceZero;
    logic useComb;
  } cellStrobe_t;

endpackage

// File: rtl/lcell_fulladd.sv
module lcell_fulladd (
  input  logic opA,
  input  logic opB,
  input  logic opC,
  output logic sumBit,
  output logic carryBit
);

  always_comb begin
    sumBit   = opA ^ opB ^ opC;
    carryBit = (opA & opB) | (opA & opC) | (opB & opC);
  end

endmodule

// File: rtl/lcell_ctrl.sv
module lcell_ctrl
  import lcell_pkg::*;
(
  input  logic [MODE_W-1:0] cfgMode,
  input  logic              bypassSel,
  output cellStrobe_t       strb
);

  always_comb begin
    strb = '0;
    unique case (cfgMode)
      MODE_LUT: strb.selLut = 1'b1;
      MODE_ADD: strb.selAdd = 1'b1;
      MODE_MUL: strb.selMul = 1'b1;
      MODE_CNT: strb.selCnt = 1'b1;
      MODE_MUX: strb.selMux = 1'b1;
      default:  strb.forceZero = 1'b1;
    endcase
    strb.regLoad = !strb.forceZero;
    strb.useComb = bypassSel;
  end

endmodule

// File: rtl/lcell_dpath.sv
module lcell_dpath
  import lcell_pkg::*;
#(
  parameter  int LUT_INPUTS = 4,
  localparam int LUT_DEPTH  = 1 << LUT_INPUTS
) (
  input  logic                  clk,
  input  logic                  rst,
  input  cellStrobe_t           strb,
  input  logic [LUT_INPUTS-1:0] dIn,
  input  logic                  carryIn,
  input  logic [LUT_DEPTH-1:0]  cfgLut,
  output logic                  funcOut,
  output logic                  carryOut,
  output logic                  regQ
);

  logic lutBit;
  logic addSum, addCy;
  logic partProd, mulSum, mulCy;
  logic funcVal;

  assign lutBit   = cfgLut[dIn];
  assign partProd = dIn[0] & dIn[1];

  lcell_fulladd i_addFa (
    .opA(dIn[0]), .opB(dIn[1]), .opC(carryIn),
    .sumBit(addSum), .carryBit(addCy)
  );

  lcell_fulladd i_mulFa (
    .opA(partProd), .opB(dIn[2]), .opC(carryIn),
    .sumBit(mulSum), .carryBit(mulCy)
  );

  // Function selection; carry leaves without any register
  always_comb begin
    funcVal  = 1'b0;
    carryOut = 1'b0;
    if (strb.selLut) begin
      funcVal = lutBit;
    end else if (strb.selAdd) begin
      funcVal  = addSum;
      carryOut = addCy;
    end else if (strb.selMul) begin
      funcVal  = mulSum;
      carryOut = mulCy;
    end else if (strb.selCnt) begin
      funcVal  = regQ ^ carryIn;
      carryOut = regQ & carryIn;
    end else if (strb.selMux) begin
      funcVal = dIn[2] ? dIn[1] : dIn[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)               regQ <= 1'b0;
    else if (strb.regLoad) regQ <= funcVal;
  end

  always_comb begin
    if (strb.forceZero)    funcOut = 1'b0;
    else if (strb.useComb) funcOut = funcVal;
    else                   funcOut = regQ;
  end

  // R2: adder arithmetic seen as an integer sum
  p_add_sum_r2: assert property (@(posedge clk) disable iff (rst)
    (strb.selAdd && strb.useComb) |->
      ({carryOut, funcOut} == ({1'b0, dIn[0]} + {1'b0, dIn[1]} + {1'b0, carryIn})));

  // R3: multiplier slice as partial product plus incoming sum and carry
  p_mul_sum_r3: assert property (@(posedge clk) disable iff (rst)
    (strb.selMul && strb.useComb) |->
      ({carryOut, funcOut} == ({1'b0, dIn[0] & dIn[1]} + {1'b0, dIn[2]} + {1'b0, carryIn})));

  // R4: counter bit inverts on an enabled edge
  p_count_toggle_r4: assert property (@(posedge clk) disable iff (rst)
    (strb.selCnt && carryIn) |=> (regQ != $past(regQ)));

  // R4: counter bit keeps its value on a disabled edge
  p_count_keep_r4: assert property (@(posedge clk) disable iff (rst)
    (strb.selCnt && !carryIn) |=> $stable(regQ));

  // R10: no carry leaves the lookup or mux functions
  p_carry_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (strb.selLut || strb.selMux) |-> (carryOut == 1'b0));

endmodule

// File: rtl/cfg_logic_cell.sv
module cfg_logic_cell
  import lcell_pkg::*;
#(
  parameter  int LUT_INPUTS = 4,
  localparam int LUT_DEPTH  = 1 << LUT_INPUTS
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [LUT_INPUTS-1:0] dIn,
  input  logic                  carryIn,
  input  logic                  outEn,
  input  logic                  bypassSel,
  input  logic [MODE_W-1:0]     cfgMode,
  input  logic [LUT_DEPTH-1:0]  cfgLut,
  output logic                  result,
  output logic                  carryOut,
  output logic                  triOut,
  output logic                  fbOut
);

  cellStrobe_t strb;
  logic        regQ;

  lcell_ctrl i_ctrl (
    .cfgMode  (cfgMode),
    .bypassSel(bypassSel),
    .strb     (strb)
  );

  lcell_dpath #(.LUT_INPUTS(LUT_INPUTS)) i_dpath (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .dIn     (dIn),
    .carryIn (carryIn),
    .cfgLut  (cfgLut),
    .funcOut (result),
    .carryOut(carryOut),
    .regQ    (regQ)
  );

  assign fbOut  = regQ;
  assign triOut = outEn ? result : 1'bz;

  // R7: registered path shows the stored bit
  p_reg_path_r7: assert property (@(posedge clk) disable iff (rst)
    (!bypassSel && (cfgMode <= MODE_MUX)) |-> (result == fbOut));

  // R11: undefined codes keep the stored bit
  p_hold_invalid_r11: assert property (@(posedge clk) disable iff (rst)
    (cfgMode > MODE_MUX) |=> $stable(fbOut));

  // R11: undefined codes drive zeros
  p_invalid_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (cfgMode > MODE_MUX) |-> (!result && !carryOut));

endmodule

// File: tb/test_cfg_logic_cell.sv
`timescale 1ns/1ps
module test_cfg_logic_cell;

  typedef struct {
    string      tag;
    logic [7:0] exp;
    int         kind;
  } sbItem_t;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;
  sbItem_t sbQ[$];

  // main cell
  logic        tRst, tCi, tOe, tByp;
  logic [3:0]  tD;
  logic [2:0]  tMode;
  logic [15:0] tLut;
  logic        result, carryOut, triOut, fbOut;
  logic        mq;

  cfg_logic_cell i_cfg_logic_cell (
    .clk(clk), .rst(tRst), .dIn(tD), .carryIn(tCi), .outEn(tOe),
    .bypassSel(tByp), .cfgMode(tMode), .cfgLut(tLut),
    .result(result), .carryOut(carryOut), .triOut(triOut), .fbOut(fbOut)
  );

  // R12 chains
  logic       chainRst, addCin, cntEn;
  logic [3:0] addA, addB, addSum, cntQ;
  logic [4:0] addCy, cntCy;
  logic [3:0] addTri, addFb, cntRes, cntTri;
  assign addCy[0] = addCin;
  assign cntCy[0] = cntEn;

  for (genvar g = 0; g < 4; g++) begin : g_chain
    cfg_logic_cell i_addCell (
      .clk(clk), .rst(chainRst), .dIn({2'b00, addB[g], addA[g]}),
      .carryIn(addCy[g]), .outEn(1'b1), .bypassSel(1'b1),
      .cfgMode(3'b001), .cfgLut(16'h0000),
      .result(addSum[g]), .carryOut(addCy[g+1]), .triOut(addTri[g]), .fbOut(addFb[g])
    );
    cfg_logic_cell i_cntCell (
      .clk(clk), .rst(chainRst), .dIn(4'b0000),
      .carryIn(cntCy[g]), .outEn(1'b1), .bypassSel(1'b0),
      .cfgMode(3'b011), .cfgLut(16'h0000),
      .result(cntRes[g]), .carryOut(cntCy[g+1]), .triOut(cntTri[g]), .fbOut(cntQ[g])
    );
  end

  // monitor: pops expectations and compares with the ports
  initial begin
    forever begin
      wait (sbQ.size() != 0);
      begin
        sbItem_t it;
        logic [7:0] act;
        it = sbQ.pop_front();
        case (it.kind)
          0:       act = {4'b0000, fbOut, carryOut, result, triOut};
          1:       act = {3'b000, addCy[4], addSum};
          default: act = {4'b0000, cntQ};
        endcase
        checks++;
        if (act !== it.exp) begin
          failures++;
          $display("FAIL %s act=%b exp=%b", it.tag, act, it.exp);
        end
      end
    end
  end

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // driver for the main cell; computes expectation from the requirements
  task automatic cellStep(input logic [2:0] m, input logic [15:0] lut, input logic [3:0] d,
                          input logic ci, input logic oe, input logic byp, input logic r,
                          input string tag);
    logic v, co, res, tri_e, nxt, bad;
    @(negedge clk);
    tMode = m; tLut = lut; tD = d; tCi = ci; tOe = oe; tByp = byp; tRst = r;
    #1;
    bad = 1'b0; co = 1'b0; v = 1'b0;
    case (m)
      3'b000: v = lut[d];
      3'b001: begin v = d[0] ^ d[1] ^ ci; co = maj3(d[0], d[1], ci); end
      3'b010: begin v = (d[0] & d[1]) ^ d[2] ^ ci; co = maj3(d[0] & d[1], d[2], ci); end
      3'b011: begin v = mq ^ ci; co = mq & ci; end
      3'b100: v = d[2] ? d[1] : d[0];
      default: bad = 1'b1;
    endcase
    res   = bad ? 1'b0 : (byp ? v : mq);
    tri_e = oe ? res : 1'bz;
    sbQ.push_back('{tag, {4'b0000, mq, co, res, tri_e}, 0});
    nxt = r ? 1'b0 : (bad ? mq : v);
    @(posedge clk);
    mq = nxt;
  endtask

  task automatic addStep(input logic [3:0] a, input logic [3:0] b, input logic ci);
    logic [4:0] s;
    @(negedge clk);
    addA = a; addB = b; addCin = ci;
    #1;
    s = {1'b0, a} + {1'b0, b} + {4'b0000, ci};
    sbQ.push_back('{"R12 ripple adder", {3'b000, s}, 1});
  endtask

  logic [3:0] cntModel;
  task automatic cntStep(input logic en);
    @(negedge clk);
    cntEn = en;
    @(posedge clk);
    #1;
    if (en) cntModel = cntModel + 4'd1;
    sbQ.push_back('{"R12 ripple counter", {4'b0000, cntModel}, 2});
  endtask

  task automatic finishRun();
    wait (sbQ.size() == 0);
    #1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog act=running exp=finished");
      sbQ.delete();
      finishRun();
    end
  end

  initial begin
    logic [15:0] pats [4];
    pats[0] = 16'hA5C3; pats[1] = 16'h8000; pats[2] = 16'h0001; pats[3] = 16'h6996;
    tRst = 1'b1; tCi = 0; tOe = 1; tByp = 1; tD = 0; tMode = 0; tLut = 0;
    chainRst = 1'b1; addA = 0; addB = 0; addCin = 0; cntEn = 0;
    cntModel = 4'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    tRst = 1'b0; chainRst = 1'b0;
    mq = 1'b0;

    // R8 / R9 reset state on the ports
    cellStep(3'b101, 16'h0, 4'h0, 0, 1, 0, 0, "R8 R9 reset state");

    // R1 lookup, every address, several tables
    for (int p = 0; p < 4; p++)
      for (int a = 0; a < 16; a++)
        cellStep(3'b000, pats[p], a[3:0], a[0], 1, 1, 0, "R1 R10 lookup");

    // R7 registered path
    for (int a = 0; a < 16; a++)
      cellStep(3'b000, 16'h3C5A, a[3:0], 0, 1, 0, 0, "R7 registered lookup");

    // R2 adder both output paths
    for (int b = 0; b < 2; b++)
      for (int a = 0; a < 32; a++)
        cellStep(3'b001, 16'h0, a[3:0], a[4], 1, b[0], 0, "R2 R10 adder");

    // R3 multiplier slice
    for (int a = 0; a < 32; a++)
      cellStep(3'b010, 16'h0, a[3:0], a[4], 1, 1, 0, "R3 R10 multiplier");
    for (int a = 0; a < 8; a++)
      cellStep(3'b010, 16'h0, a[3:0], a[1], 1, 0, 0, "R3 R7 multiplier registered");

    // R4 counter stage, mixed enables and output paths
    for (int a = 0; a < 24; a++)
      cellStep(3'b011, 16'h0, 4'h0, (a % 3) != 1, 1, a[1], 0, "R4 R9 counter stage");

    // R5 mux, R6 enable both ways
    for (int a = 0; a < 32; a++)
      cellStep(3'b100, 16'h0, a[3:0], 0, a[4], 1, 0, "R5 R6 mux");

    // R6 high impedance in other modes
    cellStep(3'b001, 16'h0, 4'h3, 1, 0, 1, 0, "R6 adder disabled");
    cellStep(3'b000, 16'hFFFF, 4'h7, 0, 0, 0, 0, "R6 lookup disabled");

    // R11 hold a one through undefined codes
    cellStep(3'b000, 16'hFFFF, 4'h0, 0, 1, 1, 0, "R11 load one");
    for (int a = 0; a < 12; a++)
      cellStep(3'b101 + a[1:0] % 3, 16'hFFFF, a[3:0], a[0], 1, a[1], 0, "R11 undefined hold");

    // R8 reset clears a stored one
    cellStep(3'b000, 16'hFFFF, 4'h0, 0, 1, 0, 1, "R8 reset edge");
    cellStep(3'b110, 16'h0, 4'h0, 0, 1, 0, 0, "R8 after reset");

    // R12 ripple adder, exhaustive
    for (int a = 0; a < 512; a++)
      addStep(a[3:0], a[7:4], a[8]);

    // R12 ripple counter: reset value, counting past wrap, pausing
    @(negedge clk); #1;
    sbQ.push_back('{"R12 counter reset", 8'h00, 2});
    for (int a = 0; a < 20; a++) cntStep(1'b1);
    for (int a = 0; a < 3; a++)  cntStep(1'b0);
    for (int a = 0; a < 5; a++)  cntStep(1'b1);

    done = 1'b1;
    finishRun();
  end

endmodule